// File: doc/BRIEF.md
# Transmit Timestamp Write-Back Controller

This block sits beside an Ethernet transmit DMA engine. It follows the buffer descriptors of each outgoing frame: the first descriptor points at an 8-byte per-frame control block, and the following one points at the layer-2 frame data. When the MAC reports that a frame has gone out on the line, the block may store the 64-bit transmit timestamp in a reserved area of host memory just after the control block. Only after that store completes does it close the frame's final descriptor and, if requested, pulse the transmit-frame event.

Write-back happens only when four things hold: a global enable, an offload flag in the first descriptor, a precision-time flag in the control block, and a frame that spans at least two descriptors. Layout faults are reported on the close handshake. A control block that is not 8 bytes long, or a store area that would straddle a 4 KB page, suppresses the store and raises an error flag. A second descriptor that is too short to satisfy the FIFO threshold still gets its store, but its close marks the timestamp as invalid. A separate capture register takes every transmit timestamp, whether or not write-back is in use.

Top module: `txts_wb_ctrl`

## Requirements
- R1: Two 32-bit memory beats are written for a frame only when `cfg_rec_en`, the first descriptor's `desc_toe`, its `fcb_ptp` and a second descriptor are all present, and R5/R6 do not apply. Otherwise no beat is issued.
- R2: The store address is the first descriptor's pointer plus 16, with bits [2:0] cleared. The first beat carries `tx_ts[63:32]` at that address. The second carries `tx_ts[31:0]` at the address plus 4.
- R3: The close of the final descriptor is offered only after the last beat is accepted. The first beat is offered the cycle after `tx_done`, and the close follows the cycle after the second beat is accepted. With no store, the close is offered the cycle after `tx_done`.
- R4: If the second descriptor has `desc_last`=0 and `desc_len` < `cfg_tx_thr`, the store still happens and the close shows `cls_ts_bad`=1, `cls_ts_ok`=0. A store with an adequate length closes with `cls_ts_ok`=1.
- R5: When bits [31:12] of the store address differ from those of the first pointer, and write-back is otherwise requested, no beat is issued and the close shows `cls_err`=1.
- R6: When write-back is requested but the first descriptor's length is not 8, no beat is issued and the close shows `cls_err`=1.
- R7: `evt_txf` pulses for one cycle, the cycle after the close is accepted, exactly when the final descriptor (the second one, or the only one) had `desc_irq`=1.
- R8: Every accepted `tx_done` loads `cap_ts` with `tx_ts` and pulses `cap_evt` the next cycle. This applies whatever the write-back settings are, and also when no frame is pending.
- R9: A `tx_done` that arrives while no frame's descriptors are complete produces no beat and no close.
- R10: Under back-pressure, `mw_valid` with its address and data, and `cls_valid` with its status flags, hold steady until accepted.
- R11: Descriptors after the second one of a frame are accepted and have no effect: neither their length nor their `desc_irq` changes the close status or the event.
- R12: After reset, `desc_ready`=1 and `mw_valid`, `cls_valid`, `evt_txf` and `cap_evt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rec_en | input | 1 | Global timestamp write-back enable |
| cfg_tx_thr | input | 16 | Transmit FIFO threshold in bytes |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted when high |
| desc_ptr | input | 32 | Descriptor buffer pointer |
| desc_len | input | 16 | Descriptor data length |
| desc_last | input | 1 | Descriptor ends the frame |
| desc_toe | input | 1 | Timestamp offload flag (first descriptor) |
| fcb_ptp | input | 1 | Precision-time flag from the control block (first descriptor) |
| desc_irq | input | 1 | Interrupt request flag |
| tx_done | input | 1 | Frame left the line, timestamp valid |
| tx_ts | input | 64 | Transmit timestamp |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory write beat accepted |
| mw_addr | output | 32 | Memory write byte address |
| mw_data | output | 32 | Memory write data |
| cls_valid | output | 1 | Close of final descriptor offered |
| cls_ready | input | 1 | Close accepted |
| cls_ts_ok | output | 1 | Timestamp stored and valid |
| cls_ts_bad | output | 1 | Timestamp stored but invalid |
| cls_err | output | 1 | Store skipped due to layout fault |
| evt_txf | output | 1 | Transmit-frame event pulse |
| cap_ts | output | 64 | Last captured timestamp |
| cap_evt | output | 1 | Capture event pulse |

## Verification
The bench counts clock edges and counts the edge that takes `tx_done` as t. With both ready inputs held high, the beats are due at edges t+1 and t+2, the close at t+3 and the event at t+4. Without a store, the close is due at t+1 and the event at t+2. The capture pulse is due at t+1 in every case. A monitor samples all handshakes on the falling edge and records the cycle of each one. The bench compares those cycle numbers with the arithmetic above. In the one frame run with toggling back-pressure, it checks only the order and the content.

// File: rtl/txts_pkg.sv
package txts_pkg;

  typedef enum logic [2:0] {
    ST_FIRST,
    ST_SECOND,
    ST_TXWAIT,
    ST_WRITE,
    ST_CLOSE
  } seq_st_e;

  typedef struct packed {
    logic ok;
    logic bad;
    logic err;
    logic irq;
  } cls_info_t;

endpackage

// File: rtl/txts_seq.sv
module txts_seq
  import txts_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int FCB_LEN    = 8,
  parameter int TS_OFF     = 16,
  parameter int ALIGN_BITS = 3,
  parameter int PAGE_BITS  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_rec_en,
  input  logic [LW-1:0] cfg_tx_thr,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [AW-1:0] desc_ptr,
  input  logic [LW-1:0] desc_len,
  input  logic          desc_last,
  input  logic          desc_toe,
  input  logic          fcb_ptp,
  input  logic          desc_irq,
  input  logic          tx_done,
  output logic          wr_start,
  output logic [AW-1:0] wr_addr,
  input  logic          wr_done,
  output logic          cls_valid,
  input  logic          cls_ready,
  output cls_info_t     cls_info,
  output logic          close_fire
);

  // Store address: pointer plus offset, forced down to the alignment grain.
  function automatic logic [AW-1:0] dest_of(input logic [AW-1:0] p);
    logic [AW-1:0] s;
    s = p + AW'(TS_OFF);
    return {s[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction

  // The reserve area lies in another page than the control block.
  function automatic logic crosses_page(input logic [AW-1:0] p);
    logic [AW-1:0] d;
    d = dest_of(p);
    return p[AW-1:PAGE_BITS] != d[AW-1:PAGE_BITS];
  endfunction

  function automatic logic len_meets(input logic [LW-1:0] len, input logic last,
                                     input logic [LW-1:0] thr);
    return last || (len >= thr);
  endfunction

  seq_st_e       st;
  logic [AW-1:0] ptr_q;
  logic          fcb_ok_q, toe_q, ptp_q, two_q, irq_q, short_q;
  cls_info_t     info_q;

  logic want, bad_lay, tx_take;

  assign want       = cfg_rec_en & toe_q & ptp_q & two_q;
  assign bad_lay    = crosses_page(ptr_q) | ~fcb_ok_q;
  assign tx_take    = (st == ST_TXWAIT) & tx_done;
  assign wr_start   = tx_take & want & ~bad_lay;
  assign wr_addr    = dest_of(ptr_q);
  assign desc_ready = (st == ST_FIRST) | (st == ST_SECOND) | (st == ST_TXWAIT);
  assign cls_valid  = (st == ST_CLOSE);
  assign close_fire = cls_valid & cls_ready;
  assign cls_info   = info_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_FIRST;
      ptr_q    <= '0;
      fcb_ok_q <= 1'b0;
      toe_q    <= 1'b0;
      ptp_q    <= 1'b0;
      two_q    <= 1'b0;
      irq_q    <= 1'b0;
      short_q  <= 1'b0;
      info_q   <= '0;
    end else begin
      unique case (st)
        ST_FIRST: if (desc_valid) begin
          ptr_q    <= desc_ptr;
          fcb_ok_q <= (desc_len == LW'(FCB_LEN));
          toe_q    <= desc_toe;
          ptp_q    <= fcb_ptp;
          irq_q    <= desc_irq;
          two_q    <= 1'b0;
          short_q  <= 1'b0;
          st       <= desc_last ? ST_TXWAIT : ST_SECOND;
        end
        ST_SECOND: if (desc_valid) begin
          two_q   <= 1'b1;
          irq_q   <= desc_irq;
          short_q <= ~len_meets(desc_len, desc_last, cfg_tx_thr);
          st      <= ST_TXWAIT;
        end
        ST_TXWAIT: if (tx_done) begin
          info_q.ok  <= wr_start & ~short_q;
          info_q.bad <= wr_start & short_q;
          info_q.err <= want & bad_lay;
          info_q.irq <= irq_q;
          st         <= wr_start ? ST_WRITE : ST_CLOSE;
        end
        ST_WRITE: if (wr_done) st <= ST_CLOSE;
        ST_CLOSE: if (cls_ready) st <= ST_FIRST;
        default: st <= ST_FIRST;
      endcase
    end
  end

endmodule

// File: rtl/txts_beat_wr.sv
module txts_beat_wr #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   addr,
  input  logic [2*DW-1:0] ts,
  output logic            mw_valid,
  input  logic            mw_ready,
  output logic [AW-1:0]   mw_addr,
  output logic [DW-1:0]   mw_data,
  output logic            done
);

  localparam int BEAT_BYTES = DW / 8;

  logic          busy, lo_beat;
  logic [AW-1:0] base_q;
  logic [DW-1:0] hi_q, lo_q;

  assign mw_valid = busy;
  assign mw_addr  = base_q + (lo_beat ? AW'(BEAT_BYTES) : '0);
  assign mw_data  = lo_beat ? lo_q : hi_q;
  assign done     = busy & lo_beat & mw_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      lo_beat <= 1'b0;
      base_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      lo_beat <= 1'b0;
      base_q  <= addr;
      hi_q    <= ts[2*DW-1:DW];
      lo_q    <= ts[DW-1:0];
    end else if (busy && mw_ready) begin
      if (lo_beat) begin
        busy    <= 1'b0;
        lo_beat <= 1'b0;
      end else begin
        lo_beat <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/txts_cap.sv
module txts_cap #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_done,
  input  logic [TW-1:0] tx_ts,
  output logic [TW-1:0] cap_ts,
  output logic          cap_evt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_ts  <= '0;
      cap_evt <= 1'b0;
    end else begin
      cap_evt <= tx_done;
      if (tx_done) cap_ts <= tx_ts;
    end
  end

endmodule

// File: rtl/txts_wb_ctrl.sv
module txts_wb_ctrl
  import txts_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int DW         = 32,
  parameter int FCB_LEN    = 8,
  parameter int TS_OFF     = 16,
  parameter int ALIGN_BITS = 3,
  parameter int PAGE_BITS  = 12,
  localparam int TW        = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_rec_en,
  input  logic [LW-1:0] cfg_tx_thr,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [AW-1:0] desc_ptr,
  input  logic [LW-1:0] desc_len,
  input  logic          desc_last,
  input  logic          desc_toe,
  input  logic          fcb_ptp,
  input  logic          desc_irq,
  input  logic          tx_done,
  input  logic [TW-1:0] tx_ts,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic          cls_valid,
  input  logic          cls_ready,
  output logic          cls_ts_ok,
  output logic          cls_ts_bad,
  output logic          cls_err,
  output logic          evt_txf,
  output logic [TW-1:0] cap_ts,
  output logic          cap_evt
);

  // Named internal events, visible to the bound checker.
  logic          wr_start;
  logic          wr_done;
  logic          close_fire;
  logic [AW-1:0] wr_addr;
  cls_info_t     info;
  logic          evt_q;

  txts_seq #(
    .AW(AW), .LW(LW), .FCB_LEN(FCB_LEN), .TS_OFF(TS_OFF),
    .ALIGN_BITS(ALIGN_BITS), .PAGE_BITS(PAGE_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_rec_en(cfg_rec_en), .cfg_tx_thr(cfg_tx_thr),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_ptr(desc_ptr), .desc_len(desc_len), .desc_last(desc_last),
    .desc_toe(desc_toe), .fcb_ptp(fcb_ptp), .desc_irq(desc_irq),
    .tx_done(tx_done),
    .wr_start(wr_start), .wr_addr(wr_addr), .wr_done(wr_done),
    .cls_valid(cls_valid), .cls_ready(cls_ready),
    .cls_info(info), .close_fire(close_fire)
  );

  txts_beat_wr #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .start(wr_start), .addr(wr_addr), .ts(tx_ts),
    .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_addr(mw_addr), .mw_data(mw_data), .done(wr_done)
  );

  txts_cap #(.TW(TW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .tx_done(tx_done), .tx_ts(tx_ts),
    .cap_ts(cap_ts), .cap_evt(cap_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= close_fire & info.irq;
  end

  assign cls_ts_ok  = info.ok;
  assign cls_ts_bad = info.bad;
  assign cls_err    = info.err;
  assign evt_txf    = evt_q;

endmodule

// File: rtl/txts_chk.sv
module txts_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_done,
  input logic          mw_valid,
  input logic          mw_ready,
  input logic [AW-1:0] mw_addr,
  input logic [DW-1:0] mw_data,
  input logic          cls_valid,
  input logic          cls_ready,
  input logic          cls_ts_ok,
  input logic          cls_ts_bad,
  input logic          cls_err,
  input logic          evt_txf,
  input logic          cap_evt,
  input logic          wr_start,
  input logic          wr_done
);

  p_beat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  p_close_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid && !cls_ready |=> cls_valid && $stable({cls_ts_ok, cls_ts_bad, cls_err}));

  p_no_close_mid_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> !mw_valid);

  p_close_follows_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> cls_valid);

  p_first_beat_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> mw_valid && (mw_addr[2:0] == 3'b000));

  p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> (mw_addr[1:0] == 2'b00));

  p_status_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> $onehot0({cls_ts_ok, cls_ts_bad, cls_err}));

  p_evt_after_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_txf |-> $past(cls_valid && cls_ready));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> cap_evt);

endmodule

bind txts_wb_ctrl txts_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_done(tx_done),
  .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
  .cls_valid(cls_valid), .cls_ready(cls_ready),
  .cls_ts_ok(cls_ts_ok), .cls_ts_bad(cls_ts_bad), .cls_err(cls_err),
  .evt_txf(evt_txf), .cap_evt(cap_evt),
  .wr_start(wr_start), .wr_done(wr_done)
);

// File: tb/sim_txts_wb_ctrl.sv
module sim_txts_wb_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rec_en = 1'b0;
  logic [15:0] cfg_tx_thr = 16'd64;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [31:0] desc_ptr = '0;
  logic [15:0] desc_len = '0;
  logic        desc_last = 1'b0, desc_toe = 1'b0, fcb_ptp = 1'b0, desc_irq = 1'b0;
  logic        tx_done = 1'b0;
  logic [63:0] tx_ts = '0;
  logic        mw_valid, mw_ready;
  logic [31:0] mw_addr, mw_data;
  logic        cls_valid, cls_ready;
  logic        cls_ts_ok, cls_ts_bad, cls_err, evt_txf, cap_evt;
  logic [63:0] cap_ts;

  logic stall = 1'b0;
  int   cyc = 0;
  int   n_chk = 0, n_bad = 0;
  bit   done_flag = 1'b0;

  always #2 clk = ~clk;

  txts_wb_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rec_en(cfg_rec_en), .cfg_tx_thr(cfg_tx_thr),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_ptr(desc_ptr),
    .desc_len(desc_len), .desc_last(desc_last), .desc_toe(desc_toe),
    .fcb_ptp(fcb_ptp), .desc_irq(desc_irq), .tx_done(tx_done), .tx_ts(tx_ts),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .cls_valid(cls_valid), .cls_ready(cls_ready), .cls_ts_ok(cls_ts_ok),
    .cls_ts_bad(cls_ts_bad), .cls_err(cls_err), .evt_txf(evt_txf),
    .cap_ts(cap_ts), .cap_evt(cap_evt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (stall) begin
      mw_ready  <= ~mw_ready;
      cls_ready <= ~cls_ready;
    end else begin
      mw_ready  <= 1'b1;
      cls_ready <= 1'b1;
    end
  end

  // Monitor: handshakes sampled on the falling edge.
  int        nwr = 0, ncls = 0, nevt = 0, ncap = 0;
  logic [31:0] wa [8];
  logic [31:0] wd [8];
  int          wc [8];
  int          c_cyc = 0, e_cyc = 0, cap_cyc = 0;
  logic [2:0]  c_flags = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mw_valid && mw_ready) begin
        wa[nwr & 7] = mw_addr;
        wd[nwr & 7] = mw_data;
        wc[nwr & 7] = cyc;
        nwr = nwr + 1;
      end
      if (cls_valid && cls_ready) begin
        c_cyc   = cyc;
        c_flags = {cls_ts_ok, cls_ts_bad, cls_err};
        ncls    = ncls + 1;
      end
      if (evt_txf) begin
        e_cyc = cyc;
        nevt  = nevt + 1;
      end
      if (cap_evt) begin
        cap_cyc = cyc;
        ncap    = ncap + 1;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // One frame: first descriptor, optional second (and third when second is not last),
  // then the transmit report and the checks.
  task automatic run_frame(input bit en, input bit toe, input bit ptp, input bit two,
                           input bit last2, input logic [31:0] ptr,
                           input logic [15:0] len1, input logic [15:0] len2,
                           input bit irq, input logic [63:0] ts, input bit exact);
    int b_wr, b_cls, b_evt, b_cap, t;
    logic [31:0] dest;
    bit px, want, err, wr, shrt;
    dest  = ((ptr + 32'd16) / 32'd8) * 32'd8;
    px    = (ptr / 32'd4096) != (dest / 32'd4096);
    want  = en && toe && ptp && two;
    err   = want && (px || len1 != 16'd8);
    wr    = want && !err;
    shrt  = two && !last2 && (len2 < cfg_tx_thr);

    @(negedge clk);
    cfg_rec_en = en;
    desc_valid = 1'b1; desc_ptr = ptr; desc_len = len1; desc_last = !two;
    desc_toe = toe; fcb_ptp = ptp; desc_irq = two ? 1'b0 : irq;
    @(negedge clk);
    if (two) begin
      desc_ptr = ptr + 32'd64; desc_len = len2; desc_last = last2;
      desc_toe = 1'b0; fcb_ptp = 1'b0; desc_irq = irq;
      @(negedge clk);
      if (!last2) begin
        // R11: trailing descriptor, its length and interrupt flag must be ignored
        desc_ptr = ptr + 32'd512; desc_len = 16'd3; desc_last = 1'b1; desc_irq = !irq;
        @(negedge clk);
      end
    end
    desc_valid = 1'b0; desc_irq = 1'b0;
    b_wr = nwr; b_cls = ncls; b_evt = nevt; b_cap = ncap;
    tx_done = 1'b1; tx_ts = ts; t = cyc;
    @(negedge clk);
    tx_done = 1'b0;
    repeat (exact ? 8 : 16) @(negedge clk);

    chk(wr ? "R1" : (err ? "R5/R6" : "R1"), "beat count", 64'(nwr - b_wr), wr ? 64'd2 : 64'd0);
    if (wr && (nwr - b_wr) == 2) begin
      chk("R2", "hi addr", 64'(wa[b_wr & 7]), 64'(dest));
      chk("R2", "hi data", 64'(wd[b_wr & 7]), 64'(ts[63:32]));
      chk("R2", "lo addr", 64'(wa[(b_wr + 1) & 7]), 64'(dest + 32'd4));
      chk("R2", "lo data", 64'(wd[(b_wr + 1) & 7]), 64'(ts[31:0]));
      chk("R3", "close after last beat", 64'(c_cyc > wc[(b_wr + 1) & 7]), 64'd1);
      if (exact) begin
        chk("R3", "hi beat cycle", 64'(wc[b_wr & 7] - t), 64'd1);
        chk("R3", "lo beat cycle", 64'(wc[(b_wr + 1) & 7] - t), 64'd2);
      end
    end
    chk("R3", "close count", 64'(ncls - b_cls), 64'd1);
    if (exact) chk("R3", "close cycle", 64'(c_cyc - t), wr ? 64'd3 : 64'd1);
    chk(err ? "R5" : (shrt ? "R4" : "R4"), "close flags {ok,bad,err}", 64'(c_flags),
        64'({wr && !shrt, wr && shrt, err}));
    chk("R7", "event count", 64'(nevt - b_evt), 64'(irq));
    if (irq && exact) chk("R7", "event cycle", 64'(e_cyc - c_cyc), 64'd1);
    chk("R8", "capture value", cap_ts, ts);
    chk("R8", "capture count", 64'(ncap - b_cap), 64'd1);
    if (exact) chk("R8", "capture cycle", 64'(cap_cyc - t), 64'd1);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "desc_ready", 64'(desc_ready), 64'd1);
    chk("R12", "mw_valid", 64'(mw_valid), 64'd0);
    chk("R12", "cls_valid", 64'(cls_valid), 64'd0);
    chk("R12", "evt_txf/cap_evt", 64'({evt_txf, cap_evt}), 64'd0);

    // R1: sweep over the four qualifying conditions
    for (int k = 0; k < 16; k++) begin
      run_frame(k[3], k[2], k[1], k[0], 1'b1, 32'h1000_0040, 16'd8, 16'd100,
                k[3] ^ k[2], {32'hA5A5_0000 + 32'(k), 32'h0F0F_1000 + 32'(k)}, 1'b1);
    end
    // R2: every misalignment of the first pointer
    for (int o = 0; o < 8; o++) begin
      run_frame(1, 1, 1, 1, 1, 32'h2000_0100 + 32'(o), 16'd8, 16'd100, 1'b1,
                {32'h1111_0000 + 32'(o), 32'h2222_0000 + 32'(o)}, 1'b1);
    end
    // R5: page crossing and its near miss
    run_frame(1, 1, 1, 1, 1, 32'h3000_0FF0, 16'd8, 16'd100, 1'b1, 64'hDEAD_BEEF_0000_0001, 1'b1);
    run_frame(1, 1, 1, 1, 1, 32'h3000_0FE8, 16'd8, 16'd100, 1'b0, 64'hDEAD_BEEF_0000_0002, 1'b1);
    run_frame(1, 1, 1, 1, 1, 32'h3000_0FEF, 16'd8, 16'd100, 1'b1, 64'hDEAD_BEEF_0000_0003, 1'b1);
    // R6: control block length not 8
    run_frame(1, 1, 1, 1, 1, 32'h4000_0000, 16'd12, 16'd100, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b1);
    // R4 and R11: short second descriptor, then whole-frame and threshold boundary
    run_frame(1, 1, 1, 1, 0, 32'h5000_0000, 16'd8, 16'd20, 1'b0, 64'h5555_0000_0000_0001, 1'b1);
    run_frame(1, 1, 1, 1, 1, 32'h5000_0000, 16'd8, 16'd20, 1'b1, 64'h5555_0000_0000_0002, 1'b1);
    run_frame(1, 1, 1, 1, 0, 32'h5000_0000, 16'd8, 16'd64, 1'b1, 64'h5555_0000_0000_0003, 1'b1);
    run_frame(1, 1, 1, 1, 0, 32'h5000_0000, 16'd8, 16'd63, 1'b1, 64'h5555_0000_0000_0004, 1'b1);
    // R10: toggling back-pressure on both handshakes
    stall = 1'b1;
    run_frame(1, 1, 1, 1, 1, 32'h6000_0008, 16'd8, 16'd100, 1'b1, 64'h7777_8888_9999_AAAA, 1'b0);
    stall = 1'b0;
    repeat (4) @(negedge clk);

    // R9: transmit report with no frame pending
    begin
      int b_wr, b_cls;
      b_wr = nwr; b_cls = ncls;
      tx_done = 1'b1; tx_ts = 64'hCAFE_F00D_0000_0009;
      @(negedge clk);
      tx_done = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9", "stray beats", 64'(nwr - b_wr), 64'd0);
      chk("R9", "stray close", 64'(ncls - b_cls), 64'd0);
      chk("R8", "capture without frame", cap_ts, 64'hCAFE_F00D_0000_0009);
    end
    finish_run();
  end

endmodule